// File: doc/BRIEF.md
# Byte-Loaded Double-Buffered Converter Code Register

This block is the digital front end of a 16-bit converter that is fed from an 8-bit host bus. Two byte-wide holding stages sit behind the bus, one for the high byte of the code and one for the low byte. A 16-bit code register sits behind them and holds the value that drives the converter. Every control pin is sampled on the rising edge of a system clock. A holding stage takes the bus value in every cycle in which its load enable is active, and keeps its last value otherwise.

A host normally writes the high byte with the byte-select line high. It then writes the low byte with the byte-select line low, and finally pulses the transfer controls to move the whole word into the code register. For automatic transfer, the board ties the transfer pin to the byte-select line and the second write strobe to the first. The low-byte write then moves the complete new word, including the new low byte, into the code register in the same cycle. The high-byte write causes no transfer. The controls are plain level pins with no handshake, so there is no back-pressure: the block accepts a write in every cycle in which the strobes are active.

Top module: `dac_byte_loader`

## Requirements
- R1: A synchronous active-high reset sets the code register and both holding stages to zero. An all-zero code means zero converter output.
- R2: While `cs_n` is high, no value on `data_in` changes either holding stage, whatever the other controls do.
- R3: With `cs_n` and `wr1_n` both low and `byte_hi` high, both the high stage and the low stage take the bus value at the clock edge.
- R4: With `cs_n` and `wr1_n` both low and `byte_hi` low, only the low stage takes the bus value. The high stage is unchanged.
- R5: The code register loads {high stage, low stage} at an edge where `xfer_n` and `wr2_n` are both low, and holds its value at every other edge.
- R6: Bit mapping: high-stage `data_in[7]` becomes `code_out[15]` and `data_in[0]` becomes `code_out[8]`. Low-stage `data_in[i]` becomes `code_out[i]`.
- R7: When a low-byte write (`byte_hi` low) and a transfer fall in the same cycle, the code register receives the new bus byte as its low byte at that same edge, together with the high stage's current value.
- R8: With automatic-transfer wiring (`xfer_n` tied to `byte_hi`, `wr2_n` tied to `wr1_n`), a high-byte write leaves `code_out` unchanged.
- R9: A holding stage keeps its value in every cycle in which its load enable is inactive, that is, whenever `wr1_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all controls sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| data_in | input | 8 | Host data bus |
| cs_n | input | 1 | Chip select, active low; qualifies the first write strobe |
| wr1_n | input | 1 | First write strobe, active low; loads the holding stages |
| wr2_n | input | 1 | Second write strobe, active low; qualifies transfer |
| xfer_n | input | 1 | Transfer request, active low |
| byte_hi | input | 1 | 1: a write loads both stages; 0: a write loads the low stage only |
| code_out | output | 16 | Code held for the converter |

## Verification
The bound checker tests, on every cycle, the stage-loading rules for each byte-select value, the isolation provided by chip select, the transfer and hold behaviour of the code register, the same-cycle bypass of the low byte during a combined write and transfer, and the reset value. Other behaviours only show up across several cycles and are left to bench scenarios checked against a reference model. These are whole host sequences: the three-step normal load, the automatic-transfer pair in which the high-byte write must not move the code, a high-byte-only partial update that also overwrites the low byte, and long random mixes of strobes, in which stale or corrupted stage contents become visible at the next transfer.

// File: rtl/dac_load_pkg.sv
package dac_load_pkg;

  // Decoded per-cycle actions derived from the control pins
  typedef struct packed {
    logic ld_hi;  // high holding stage takes the bus
    logic ld_lo;  // low holding stage takes the bus
    logic xfer;   // code register takes both stages
  } load_ctrl_t;

  localparam int unsigned NUM_STAGES = 2;
  localparam int unsigned STAGE_LO   = 0;
  localparam int unsigned STAGE_HI   = 1;

endpackage

// File: rtl/dac_load_decode.sv
module dac_load_decode
  import dac_load_pkg::*;
(
  input  logic       cs_n,
  input  logic       wr1_n,
  input  logic       wr2_n,
  input  logic       xfer_n,
  input  logic       byte_hi,
  output load_ctrl_t ctrl
);

  logic write_en;

  always_comb begin
    // chip select qualifies the first strobe only
    write_en   = ~cs_n & ~wr1_n;
    ctrl.ld_lo = write_en;
    ctrl.ld_hi = write_en & byte_hi;
    ctrl.xfer  = ~xfer_n & ~wr2_n;
  end

endmodule

// File: rtl/dac_hold_stage.sv
module dac_hold_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_next
);

  // value the stage will hold after this edge; used as a bypass
  always_comb q_next = en ? d : q;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= q_next;
  end

endmodule

// File: rtl/dac_code_reg.sv
module dac_code_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end

endmodule

// File: rtl/dac_byte_loader.sv
module dac_byte_loader
  import dac_load_pkg::*;
#(
  parameter int unsigned BUS_W = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [BUS_W-1:0]                data_in,
  input  logic                            cs_n,
  input  logic                            wr1_n,
  input  logic                            wr2_n,
  input  logic                            xfer_n,
  input  logic                            byte_hi,
  output logic [NUM_STAGES*BUS_W-1:0]     code_out
);

  localparam int unsigned CODE_W = NUM_STAGES * BUS_W;

  load_ctrl_t                               ctrl;
  logic [NUM_STAGES-1:0]                    stage_en;
  logic [NUM_STAGES-1:0][BUS_W-1:0]         stage_q;
  logic [NUM_STAGES-1:0][BUS_W-1:0]         stage_nxt;
  logic [BUS_W-1:0]                         upper_q;
  logic [BUS_W-1:0]                         lower_q;

  dac_load_decode u_decode (
    .cs_n    (cs_n),
    .wr1_n   (wr1_n),
    .wr2_n   (wr2_n),
    .xfer_n  (xfer_n),
    .byte_hi (byte_hi),
    .ctrl    (ctrl)
  );

  always_comb begin
    stage_en           = '0;
    stage_en[STAGE_LO] = ctrl.ld_lo;
    stage_en[STAGE_HI] = ctrl.ld_hi;
  end

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    dac_hold_stage #(.W(BUS_W)) u_stage (
      .clk    (clk),
      .rst    (rst),
      .en     (stage_en[g]),
      .d      (data_in),
      .q      (stage_q[g]),
      .q_next (stage_nxt[g])
    );
  end

  assign upper_q = stage_q[STAGE_HI];
  assign lower_q = stage_q[STAGE_LO];

  // stage_nxt packs the high stage into the upper code bits
  dac_code_reg #(.W(CODE_W)) u_code (
    .clk  (clk),
    .rst  (rst),
    .load (ctrl.xfer),
    .d    (stage_nxt),
    .q    (code_out)
  );

endmodule

// File: rtl/dac_byte_loader_chk.sv
module dac_byte_loader_chk #(
  parameter int unsigned BUS_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [BUS_W-1:0]   data_in,
  input logic               cs_n,
  input logic               wr1_n,
  input logic               wr2_n,
  input logic               xfer_n,
  input logic               byte_hi,
  input logic [2*BUS_W-1:0] code_out,
  input logic [BUS_W-1:0]   upper_q,
  input logic [BUS_W-1:0]   lower_q
);

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (code_out == '0 && upper_q == '0 && lower_q == '0));

  a_r2_cs_isolates: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> ($stable(upper_q) && $stable(lower_q)));

  a_r3_both_stages: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !wr1_n && byte_hi) |=>
      (upper_q == $past(data_in) && lower_q == $past(data_in)));

  a_r4_low_only: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !wr1_n && !byte_hi) |=>
      ($stable(upper_q) && lower_q == $past(data_in)));

  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (xfer_n || wr2_n) |=> $stable(code_out));

  a_r5_r6_transfer: assert property (@(posedge clk) disable iff (rst)
    (!xfer_n && !wr2_n && wr1_n) |=>
      (code_out == {$past(upper_q), $past(lower_q)}));

  a_r7_bypass: assert property (@(posedge clk) disable iff (rst)
    (!xfer_n && !wr2_n && !cs_n && !wr1_n && !byte_hi) |=>
      (code_out == {$past(upper_q), $past(data_in)}));

  a_r9_stage_hold: assert property (@(posedge clk) disable iff (rst)
    wr1_n |=> ($stable(upper_q) && $stable(lower_q)));

endmodule

bind dac_byte_loader dac_byte_loader_chk #(.BUS_W(BUS_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .data_in  (data_in),
  .cs_n     (cs_n),
  .wr1_n    (wr1_n),
  .wr2_n    (wr2_n),
  .xfer_n   (xfer_n),
  .byte_hi  (byte_hi),
  .code_out (code_out),
  .upper_q  (upper_q),
  .lower_q  (lower_q)
);

// File: tb/tb_dac_byte_loader.sv
`timescale 1ns/1ps
module tb_dac_byte_loader;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  data_in = '0;
  logic        cs_n = 1'b1, wr1_n = 1'b1, wr2_n = 1'b1, xfer_n = 1'b1, byte_hi = 1'b0;
  logic [15:0] code_out;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  // reference model state
  logic [7:0]  m_up = '0, m_lo = '0;
  logic [15:0] m_code = '0;

  always #2.5 clk = ~clk;

  dac_byte_loader dut (
    .clk(clk), .rst(rst), .data_in(data_in), .cs_n(cs_n), .wr1_n(wr1_n),
    .wr2_n(wr2_n), .xfer_n(xfer_n), .byte_hi(byte_hi), .code_out(code_out)
  );

  function automatic logic [7:0] next_up(logic [7:0] up, logic [7:0] d,
                                         logic cs, logic w1, logic bh);
    return (!cs && !w1 && bh) ? d : up;
  endfunction

  function automatic logic [7:0] next_lo(logic [7:0] lo, logic [7:0] d,
                                         logic cs, logic w1);
    return (!cs && !w1) ? d : lo;
  endfunction

  task automatic check(input string req, input logic [15:0] exp);
    checks++;
    if (code_out !== exp) begin
      fails++;
      $display("FAIL %s: code_out=%h expected=%h", req, code_out, exp);
    end
  endtask

  // one clocked bus cycle, then a check of code_out against the model
  task automatic step(input string req, input logic cs, input logic w1,
                      input logic w2, input logic xf, input logic bh,
                      input logic [7:0] d);
    logic [7:0] nu, nl;
    cs_n = cs; wr1_n = w1; wr2_n = w2; xfer_n = xf; byte_hi = bh; data_in = d;
    nu = next_up(m_up, d, cs, w1, bh);
    nl = next_lo(m_lo, d, cs, w1);
    if (!xf && !w2) m_code = {nu, nl};
    m_up = nu; m_lo = nl;
    @(posedge clk);
    @(negedge clk);
    check(req, m_code);
  endtask

  task automatic idle(input string req);
    step(req, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'hEE);
  endtask

  task automatic xfer_only(input string req);
    step(req, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h99);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      fails++;
      $display("FAIL watchdog: cycles=%0d expected=<20000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset code", 16'h0000);
    xfer_only("R1 stages cleared by reset");

    // normal three-step sequence
    step("R5 hold after high write", 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'hA5);
    step("R4 low write", 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h3C);
    idle("R5 hold before transfer");
    xfer_only("R5 R6 transfer A53C");
    check("R6 expect A53C", 16'hA53C);

    // bit mapping extremes
    step("R3", 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h80);
    step("R4", 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h01);
    xfer_only("R6 bit mapping");
    check("R6 expect 8001", 16'h8001);

    // chip select high must leave the stages alone
    step("R2 cs high, high write", 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'hFF);
    step("R2 cs high, low write", 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'hFF);
    xfer_only("R2 stages untouched");
    check("R2 expect 8001", 16'h8001);

    // write strobe high: stages hold
    step("R9 wr1 high", 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h55);
    xfer_only("R9 stages held");
    check("R9 expect 8001", 16'h8001);

    // low-only update keeps high byte
    step("R4 low only", 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h77);
    xfer_only("R4 transfer");
    check("R4 expect 8077", 16'h8077);

    // high-byte-only partial update also overwrites the low byte
    step("R3 high write", 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h12);
    xfer_only("R3 transfer");
    check("R3 expect 1212", 16'h1212);

    // automatic transfer wiring: xfer_n = byte_hi, wr2_n = wr1_n
    step("R8 auto high write", 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'hC3);
    check("R8 code unchanged", 16'h1212);
    step("R7 auto low write", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h5A);
    check("R7 expect C35A", 16'hC35A);
    step("R8 auto high write 2", 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h0F);
    step("R7 auto low write 2", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hF0);
    check("R7 expect 0FF0", 16'h0FF0);

    // random mix of strobes
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] r;
      r = 4'($urandom());
      step("R5 random", r[0], r[1], r[2], 1'($urandom_range(0, 2) == 0),
           r[3], 8'($urandom()));
    end

    // mid-run reset
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_up = '0; m_lo = '0; m_code = '0;
    check("R1 mid-run reset", 16'h0000);
    xfer_only("R1 stages cleared again");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule